// File: doc/BRIEF.md
# Frame-Gated Synchronous Serial Transmitter

This block is the transmit side of one channel of a frame-based synchronous serial port. Software places a word in a holding register. When a frame begins, the channel either takes part in the frame or stays out of it for the whole frame. A channel that takes part moves the held word into a shift register at the start of each word slot and shifts it out, most significant bit first, one bit per bit-clock cycle. A frame may hold one slot (normal mode) or several back-to-back slots (network mode).

The channel enable is a register bit inside the block. It is looked at only when a frame sync arrives. Clearing it in the middle of a frame lets the word already in the shift register finish, and then the channel stops. A channel that is disabled when a frame begins hands its data pin over to a general-purpose flag value for that frame. In asynchronous mode the enable bit has no effect, and every frame is sent.

Top module: `fgs_tx`

## Requirements
- R1: The enable bit (`en_state`) reads 0 after `rst_n` and in the cycle after a `soft_rst` pulse, whatever `en_wr` does in that cycle. Otherwise `en_wr` writes `en_wdata` into it.
- R2: A clock edge with `fsync`=1 and the enable set (synchronous mode) starts a frame. From the next cycle on, `sd_out` carries the loaded word MSB first, one bit per cycle for WORD_W cycles.
- R3: Setting the enable while no frame is being sent starts nothing. `sd_out` does not carry data until the next `fsync` edge.
- R4: If the enable is 0 at a slot boundary inside a frame, the word already shifting still completes. The next slot is then not loaded, and `sd_out` goes low until the next `fsync`.
- R5: While the channel is disabled, a write is accepted and clears `tde`. The written word is not moved into the shift register, so `tde` stays 0 across frame syncs that find the enable cleared.
- R6: After an `fsync` edge that finds the channel disabled, `sd_out` follows `flag_val` combinationally until a frame is started again. This holds in both normal and network mode.
- R7: With `sync_mode`=0, the enable bit is ignored and every `fsync` starts a full frame.
- R8: `tde` is 1 after reset and 0 in the cycle after a write. It becomes 1 again after the held word is loaded into the shift register. A write in the same cycle as a load wins, and `tde` stays 0.
- R9: A load that finds `tde`=1 sends the previously held word again and sets `underrun`. `underrun` is cleared by a write, unless a new underrun occurs in that same cycle.
- R10: A frame has SLOTS back-to-back slots of WORD_W bits. Each slot start loads the holding register. After the last slot `sd_out` is low.
- R11: An `fsync` edge in the middle of a frame abandons the current word and begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset pulse; clears the enable bit |
| sync_mode | input | 1 | 1 = synchronous mode (enable honoured), 0 = asynchronous |
| fsync | input | 1 | Frame sync, sampled on the rising edge |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | WORD_W | Word written to the holding register |
| flag_val | input | 1 | Flag value shown on the pin of a disabled channel |
| sd_out | output | 1 | Serial data / flag pin |
| tde | output | 1 | Holding register empty |
| underrun | output | 1 | Sticky: a slot reloaded a stale word |
| en_state | output | 1 | Current value of the enable bit |

## Verification
The bench builds the block with 8-bit words and two slots per frame, which is network mode. This puts both an in-frame slot boundary and the end of a frame within a 16-cycle window, so slot-to-slot loading, underrun on the second slot and the stop-after-current-word path are all reached. A run of randomised enable writes, software resets, mode changes and frame syncs at uneven spacing also hits frame syncs that land mid-word and writes that coincide with loads.

// File: rtl/fgs_pkg.sv
package fgs_pkg;

   // Source driving the serial pin
   typedef enum logic [1:0] {
      PIN_IDLE = 2'd0,
      PIN_DATA = 2'd1,
      PIN_FLAG = 2'd2
   } pin_src_e;

endpackage

// File: rtl/fgs_hold.sv
module fgs_hold #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              load,
   output logic [WORD_W-1:0] hold_q,
   output logic              empty,
   output logic              urun
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         empty  <= 1'b1;
         urun   <= 1'b0;
      end else begin
         if (wr)
            hold_q <= wdata;
         if (wr)
            empty <= 1'b0;
         else if (load)
            empty <= 1'b1;
         if (load && empty)
            urun <= 1'b1;
         else if (wr)
            urun <= 1'b0;
      end
   end

   assert_write_clears_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !empty);
   assert_load_sets_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr) |=> empty);
   assert_stale_load_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && empty) |=> urun);
   assert_stale_load_same_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && empty && !wr) |=> $stable(hold_q));

endmodule

// File: rtl/fgs_shift.sv
module fgs_shift #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [WORD_W-1:0] din,
   output logic              msb
);

   logic [WORD_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr <= '0;
      else if (load)
         sr <= din;
      else if (shift)
         sr <= {sr[WORD_W-2:0], 1'b0};
   end

   assign msb = sr[WORD_W-1];

   assert_first_bit_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (msb == $past(din[WORD_W-1])));
   assert_next_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> (msb == $past(sr[WORD_W-2])));

endmodule

// File: rtl/fgs_seq.sv
module fgs_seq
   import fgs_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int SLOTS  = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     soft_rst,
   input  logic     sync_mode,
   input  logic     fsync,
   input  logic     en_wr,
   input  logic     en_wdata,
   output logic     load,
   output logic     shift,
   output logic     en_q,
   output pin_src_e pin_sel
);

   localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0] bitcnt;
   logic             shifting;
   logic             gated;
   logic             last_slot;
   logic             eff;
   logic             slot_end;

   // enable counts only in synchronous mode
   assign eff      = en_q | ~sync_mode;
   assign slot_end = shifting & (bitcnt == '0);
   assign load     = fsync ? eff : (slot_end & ~last_slot & eff);
   assign shift    = shifting & ~fsync & ~slot_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (soft_rst)
         en_q <= 1'b0;
      else if (en_wr)
         en_q <= en_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shifting <= 1'b0;
         gated    <= 1'b1;
         bitcnt   <= '0;
      end else begin
         if (fsync) begin
            shifting <= eff;
            gated    <= ~eff;
         end else if (slot_end) begin
            shifting <= load;
         end
         if (load)
            bitcnt <= LAST_BIT;
         else if (shift)
            bitcnt <= bitcnt - 1'b1;
      end
   end

   generate
      if (SLOTS == 1) begin : g_normal
         assign last_slot = 1'b1;
      end else begin : g_network
         localparam int SLOT_W = $clog2(SLOTS);
         logic [SLOT_W-1:0] slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot <= '0;
            else if (load && fsync)
               slot <= '0;
            else if (load)
               slot <= slot + 1'b1;
         end
         assign last_slot = (slot == SLOT_W'(SLOTS - 1));
      end
   endgenerate

   always_comb begin
      if (shifting)
         pin_sel = PIN_DATA;
      else if (gated)
         pin_sel = PIN_FLAG;
      else
         pin_sel = PIN_IDLE;
   end

   assert_sw_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !en_q);
   assert_no_start_midframe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel != PIN_DATA && !fsync) |=> (pin_sel != PIN_DATA));
   assert_word_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (shifting && !fsync && bitcnt != '0) |=> (pin_sel == PIN_DATA));
   assert_stop_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && !eff && !fsync) |=> (pin_sel == PIN_IDLE));
   assert_flag_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && !eff) |=> (pin_sel == PIN_FLAG));
   assert_async_sends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && !sync_mode) |=> (pin_sel == PIN_DATA));

endmodule

// File: rtl/fgs_tx.sv
module fgs_tx
   import fgs_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int SLOTS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              sync_mode,
   input  logic              fsync,
   input  logic              en_wr,
   input  logic              en_wdata,
   input  logic              hold_wr,
   input  logic [WORD_W-1:0] hold_wdata,
   input  logic              flag_val,
   output logic              sd_out,
   output logic              tde,
   output logic              underrun,
   output logic              en_state
);

   initial begin
      assert (WORD_W >= 8 && WORD_W <= 24)
         else $error("fgs_tx: WORD_W must lie in 8..24");
      assert (SLOTS >= 1 && SLOTS <= 32)
         else $error("fgs_tx: SLOTS must lie in 1..32");
   end

   logic              load;
   logic              shift;
   logic              msb;
   logic [WORD_W-1:0] hold_q;
   pin_src_e          pin_sel;

   fgs_seq #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .sync_mode(sync_mode),
      .fsync    (fsync),
      .en_wr    (en_wr),
      .en_wdata (en_wdata),
      .load     (load),
      .shift    (shift),
      .en_q     (en_state),
      .pin_sel  (pin_sel)
   );

   fgs_hold #(.WORD_W(WORD_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (hold_wr),
      .wdata (hold_wdata),
      .load  (load),
      .hold_q(hold_q),
      .empty (tde),
      .urun  (underrun)
   );

   fgs_shift #(.WORD_W(WORD_W)) u_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load),
      .shift(shift),
      .din  (hold_q),
      .msb  (msb)
   );

   always_comb begin
      case (pin_sel)
         PIN_DATA: sd_out = msb;
         PIN_FLAG: sd_out = flag_val;
         default:  sd_out = 1'b0;
      endcase
   end

   assert_flag_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel == PIN_FLAG) |-> (sd_out == flag_val));

endmodule

// File: tb/sim_fgs_tx.sv
module sim_fgs_tx;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int S = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         soft_rst = 1'b0;
   logic         sync_mode = 1'b1;
   logic         fsync = 1'b0;
   logic         en_wr = 1'b0;
   logic         en_wdata = 1'b0;
   logic         hold_wr = 1'b0;
   logic [W-1:0] hold_wdata = '0;
   logic         flag_val = 1'b0;
   logic         sd_out, tde, underrun, en_state;

   int    n_vec  = 0;
   int    n_bad  = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   fgs_tx #(.WORD_W(W), .SLOTS(S)) u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sync_mode(sync_mode),
      .fsync(fsync), .en_wr(en_wr), .en_wdata(en_wdata), .hold_wr(hold_wr),
      .hold_wdata(hold_wdata), .flag_val(flag_val), .sd_out(sd_out),
      .tde(tde), .underrun(underrun), .en_state(en_state)
   );

   // ---------------- behavioural reference ----------------
   bit           m_q[$];
   int           m_slots_done = 0;
   bit           m_act = 0, m_flag = 1, m_en = 0, m_tde = 1, m_und = 0;
   logic [W-1:0] m_hold = '0;
   bit           m_eff, m_ld, m_old_tde;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         m_act = 0; m_flag = 1; m_en = 0; m_tde = 1; m_und = 0; m_hold = '0;
         m_slots_done = 0;
      end else begin
         m_eff = m_en || !sync_mode;
         m_ld = 0;
         m_old_tde = m_tde;
         if (fsync) begin
            m_q.delete();
            if (m_eff) begin m_act = 1; m_slots_done = 0; m_ld = 1; m_flag = 0; end
            else begin m_act = 0; m_flag = 1; end
         end else if (m_act) begin
            void'(m_q.pop_front());
            if (m_q.size() == 0) begin
               m_slots_done++;
               if (m_slots_done < S && m_eff) m_ld = 1;
               else m_act = 0;
            end
         end
         if (m_ld)
            for (int i = W-1; i >= 0; i--) m_q.push_back(m_hold[i]);
         if (m_ld && m_old_tde) m_und = 1;
         else if (hold_wr) m_und = 0;
         if (hold_wr) begin m_tde = 0; m_hold = hold_wdata; end
         else if (m_ld) m_tde = 1;
         if (soft_rst) m_en = 0;
         else if (en_wr) m_en = en_wdata;
      end
   end

   function automatic bit exp_sd();
      if (m_act) return m_q[0];
      if (m_flag) return flag_val;
      return 1'b0;
   endfunction

   task automatic cmp(string what, logic act, logic exp);
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
      n_vec++;
      cmp("sd_out",   sd_out,   exp_sd());
      cmp("tde",      tde,      m_tde);
      cmp("underrun", underrun, m_und);
      cmp("en_state", en_state, m_en);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) nxt();
   endtask

   task automatic pulse_fsync();
      fsync = 1'b1; nxt(); fsync = 1'b0;
   endtask

   task automatic write_hold(logic [W-1:0] d);
      hold_wr = 1'b1; hold_wdata = d; nxt(); hold_wr = 1'b0;
   endtask

   task automatic write_en(logic v);
      en_wr = 1'b1; en_wdata = v; nxt(); en_wr = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";   idle(2);                      // reset: en 0, tde 1, pin = flag
      cur_req = "R6";   flag_val = 1'b1; idle(2); flag_val = 1'b0; idle(1);

      cur_req = "R2";   write_en(1'b1); write_hold(8'hA5); idle(2);
      pulse_fsync(); idle(3);
      cur_req = "R10";  write_hold(8'h3C); idle(14);  // second slot carries 3C, then idle low

      cur_req = "R9";   pulse_fsync(); idle(20);      // empty at load: reload 3C, underrun
      cur_req = "R8";   write_hold(8'h81); idle(2);   // write clears tde and underrun

      cur_req = "R4";   pulse_fsync(); idle(2);
      write_en(1'b0); write_hold(8'h5A); idle(16);    // word finishes, slot 2 not loaded

      cur_req = "R6";   pulse_fsync();
      flag_val = 1'b1; idle(3); flag_val = 1'b0; idle(2); flag_val = 1'b1; idle(2);
      cur_req = "R5";   write_hold(8'hC3); pulse_fsync(); idle(10); pulse_fsync(); idle(4);

      cur_req = "R3";   write_en(1'b1); idle(12);     // no data until next frame sync
      cur_req = "R2";   pulse_fsync(); idle(18);

      cur_req = "R1";   write_hold(8'h0F); pulse_fsync(); idle(3);
      soft_rst = 1'b1; en_wr = 1'b1; en_wdata = 1'b1; nxt();
      soft_rst = 1'b0; en_wr = 1'b0; idle(16);

      cur_req = "R7";   sync_mode = 1'b0; write_hold(8'hE7);
      pulse_fsync(); idle(18); sync_mode = 1'b1;

      cur_req = "R11";  write_en(1'b1); write_hold(8'h96);
      pulse_fsync(); idle(4); write_hold(8'h69); pulse_fsync(); idle(18);

      cur_req = "R8";   write_hold(8'h11); pulse_fsync(); idle(7);
      hold_wr = 1'b1; hold_wdata = 8'h22; nxt(); hold_wr = 1'b0; idle(10); // write on slot load

      cur_req = "R2";                                 // randomised mix
      for (int k = 0; k < 4000; k++) begin
         fsync     = ($urandom_range(0, 22) == 0);
         hold_wr   = ($urandom_range(0, 9) == 0);
         hold_wdata = W'($urandom);
         en_wr     = ($urandom_range(0, 30) == 0);
         en_wdata  = ($urandom_range(0, 3) != 0);
         soft_rst  = ($urandom_range(0, 200) == 0);
         flag_val  = $urandom_range(0, 1) != 0;
         if ($urandom_range(0, 300) == 0) sync_mode = ~sync_mode;
         nxt();
      end
      fsync = 0; hold_wr = 0; en_wr = 0; soft_rst = 0;
      idle(4);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule